// File: doc/BRIEF.md
# Coprocessor Instruction Stream Tracker

This block sits next to a host processor on a shared bus where address and data use the same pins. It never receives instructions from the host. Instead it watches every bus cycle and notes the cycle type during the address phase. It writes each instruction-fetch byte into a shadow byte queue, so the shadow queue matches the host's own prefetch queue.

A two-bit queue-status code from the host tells the tracker when the host has taken a byte from its queue and when the queue was flushed. The first byte of each instruction is tested for a coprocessor escape opcode. For an escape, the next byte taken is the ModRM byte, and the tracker then reports the decoded instruction. If the ModRM byte names a memory operand, the host issues a dummy read. The tracker records the address of that read and then the data returned with it.

Top module: `esc_stream_tracker`

## Requirements
- R1: A synchronous active-high `rst` empties the shadow queue, clears the decode state and the capture state, and drives every output to zero from the first clock edge after it.
- R2: A byte on `bus_ad[7:0]` enters the shadow queue only in the data phase of a cycle whose address phase had `cyc_read`=1 and `cyc_fetch`=1. Write cycles and non-fetch reads add nothing to the queue.
- R3: Bytes leave the shadow queue in the order they arrived. `q_status` code 01 (first byte) and code 11 (next byte) each remove one byte. Code 00 removes nothing.
- R4: `q_status` code 10 (flush) empties the shadow queue at that clock edge and cancels an escape that is still waiting for its ModRM byte. A fetch byte arriving in the same cycle is dropped.
- R5: A first byte whose top five bits are 11011 (0xD8 to 0xDF) starts an escape. Any other first byte is discarded and produces no strobe. The next-byte pops that follow it are ignored as well.
- R6: After an escape, the next-byte pop supplies the ModRM byte. One clock edge later, `insn_stb` is high for one cycle and `insn_opcode` and `insn_modrm` show the two bytes. `insn_has_mem` is 1 exactly when ModRM bits [7:6] are not 11.
- R7: Only a decode with `insn_has_mem`=1 arms address capture. The first non-fetch read address phase after that decode latches `bus_ad` into `op_addr`, and `addr_stb` is high for one cycle at the same edge.
- R8: The data phase of that same dummy read latches `bus_ad` into `op_data`, and `data_stb` is high for one cycle. Capture then stays disarmed until the next memory-form escape.
- R9: The shadow queue holds DEPTH bytes (6 by default). A fetch byte that arrives while the queue is full, with no pop in the same cycle, is dropped, and `ovf_err` goes high and stays high until reset.
- R10: A first-byte or next-byte code while the queue is empty removes nothing and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ad | input | AW | Shared bus: address in the address phase, data in the data phase |
| addr_phase | input | 1 | Address phase of a bus cycle |
| data_phase | input | 1 | Data phase of a bus cycle |
| cyc_read | input | 1 | Cycle is a read (sampled in the address phase) |
| cyc_fetch | input | 1 | Cycle is an instruction fetch (sampled in the address phase) |
| q_status | input | 2 | Host queue status: 00 idle, 01 first byte, 10 flush, 11 next byte |
| insn_stb | output | 1 | One-cycle pulse: an escape instruction has been decoded |
| insn_opcode | output | 8 | Escape opcode of the last decoded instruction |
| insn_modrm | output | 8 | ModRM byte of the last decoded instruction |
| insn_has_mem | output | 1 | Last decoded instruction has a memory operand |
| addr_stb | output | 1 | One-cycle pulse: operand address captured |
| op_addr | output | AW | Captured operand address |
| data_stb | output | 1 | One-cycle pulse: operand data captured |
| op_data | output | AW | Captured operand data |
| ovf_err | output | 1 | Sticky shadow-queue overflow flag |

## Verification
Every result is registered. `insn_stb` with its opcode and ModRM bytes appears after the clock edge that samples the next-byte code. `addr_stb` and `op_addr` appear after the edge that samples the dummy read's address phase. `data_stb` and `op_data` appear after the edge that samples its data phase. `ovf_err` rises after the edge that samples the dropped fetch byte.

The bench holds the inputs steady across an edge and updates a behavioural model with a byte queue at that same edge. One time unit later it compares every output with the model. Each result is therefore checked in the cycle it is due, and a pulse that arrives early, arrives late or lasts two cycles is caught.

// File: rtl/esc_trk_pkg.sv
package esc_trk_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_ADDR = 2'd1,
        CAP_DATA = 2'd2
    } cap_e;

    typedef enum logic {
        DEC_IDLE  = 1'b0,
        DEC_MODRM = 1'b1
    } dec_e;

    localparam logic [4:0] ESC_TOP = 5'b11011;

    function automatic logic is_esc(input logic [7:0] b);
        return b[7:3] == ESC_TOP;
    endfunction

    function automatic logic mem_form(input logic [7:0] m);
        return m[7:6] != 2'b11;
    endfunction

endpackage

// File: rtl/esc_bus_latch.sv
module esc_bus_latch (
    input  logic clk,
    input  logic rst,
    input  logic addr_phase,
    input  logic data_phase,
    input  logic cyc_read,
    input  logic cyc_fetch,
    output logic ev_fetch_push,
    output logic ev_dummy_addr,
    output logic ev_dummy_data
);
    typedef struct packed {
        logic rd;
        logic fetch;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (addr_phase) begin
            lat_d.rd    = cyc_read;
            lat_d.fetch = cyc_fetch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    // data phase is judged by the type recorded in the earlier address phase
    assign ev_fetch_push = data_phase & lat_q.rd & lat_q.fetch;
    assign ev_dummy_data = data_phase & lat_q.rd & ~lat_q.fetch;
    assign ev_dummy_addr = addr_phase & cyc_read & ~cyc_fetch;
endmodule

// File: rtl/esc_shadow_queue.sv
module esc_shadow_queue #(
    parameter  int DEPTH = 6,
    parameter  int BW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [BW-1:0] push_data,
    input  logic          pop,
    output logic [BW-1:0] head,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } qst_t;

    qst_t q_d, q_q;
    logic pop_ok, push_ok;
    logic [DEPTH-1:0] we;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = pop && (q_q.cnt != '0);
    assign push_ok = push && ((q_q.cnt != CW'(DEPTH)) || pop_ok) && !flush;

    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign we[g] = push_ok && (q_q.wr == PW'(g));
    end

    always_comb begin
        q_d = q_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we[i]) q_d.mem[i] = push_data;
        end
        if (flush) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (pop_ok)  q_d.rd = nxt(q_q.rd);
            if (push_ok) q_d.wr = nxt(q_q.wr);
            else if (push) q_d.ovf = 1'b1;
            q_d.cnt = q_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    always_comb begin
        head = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_q.rd == PW'(i)) head = q_q.mem[i];
        end
    end

    assign empty    = (q_q.cnt == '0);
    assign count    = q_q.cnt;
    assign overflow = q_q.ovf;
endmodule

// File: rtl/esc_decoder.sv
module esc_decoder
    import esc_trk_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    q_status,
    input  logic [7:0]    head,
    input  logic          q_empty,
    input  logic          ev_dummy_addr,
    input  logic          ev_dummy_data,
    input  logic [AW-1:0] bus_ad,
    output logic          q_pop,
    output logic          q_flush,
    output logic          insn_stb,
    output logic [7:0]    insn_opcode,
    output logic [7:0]    insn_modrm,
    output logic          insn_has_mem,
    output logic          addr_stb,
    output logic [AW-1:0] op_addr,
    output logic          data_stb,
    output logic [AW-1:0] op_data
);
    typedef struct packed {
        dec_e          st;
        logic [7:0]    pend_op;
        logic [7:0]    opc;
        logic [7:0]    modrm;
        logic          has_mem;
        logic          istb;
        cap_e          cap;
        logic [AW-1:0] addr;
        logic [AW-1:0] data;
        logic          astb;
        logic          dstb;
    } dst_t;

    dst_t s_d, s_q;
    qstat_e qs;
    logic take;

    assign qs      = qstat_e'(q_status);
    assign take    = ((qs == QS_FIRST) || (qs == QS_NEXT)) && !q_empty;
    assign q_pop   = take;
    assign q_flush = (qs == QS_FLUSH);

    always_comb begin
        s_d      = s_q;
        s_d.istb = 1'b0;
        s_d.astb = 1'b0;
        s_d.dstb = 1'b0;

        // dummy-read capture, using the arming state held before this edge
        if (s_q.cap == CAP_ADDR && ev_dummy_addr) begin
            s_d.addr = bus_ad;
            s_d.astb = 1'b1;
            s_d.cap  = CAP_DATA;
        end else if (s_q.cap == CAP_DATA && ev_dummy_data) begin
            s_d.data = bus_ad;
            s_d.dstb = 1'b1;
            s_d.cap  = CAP_OFF;
        end

        unique case (qs)
            QS_FLUSH: s_d.st = DEC_IDLE;
            QS_FIRST: begin
                if (take && is_esc(head)) begin
                    s_d.st      = DEC_MODRM;
                    s_d.pend_op = head;
                end else begin
                    s_d.st = DEC_IDLE;
                end
            end
            QS_NEXT: begin
                if (take && s_q.st == DEC_MODRM) begin
                    s_d.opc     = s_q.pend_op;
                    s_d.modrm   = head;
                    s_d.has_mem = mem_form(head);
                    s_d.istb    = 1'b1;
                    s_d.cap     = mem_form(head) ? CAP_ADDR : CAP_OFF;
                    s_d.st      = DEC_IDLE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign insn_stb     = s_q.istb;
    assign insn_opcode  = s_q.opc;
    assign insn_modrm   = s_q.modrm;
    assign insn_has_mem = s_q.has_mem;
    assign addr_stb     = s_q.astb;
    assign op_addr      = s_q.addr;
    assign data_stb     = s_q.dstb;
    assign op_data      = s_q.data;
endmodule

// File: rtl/esc_stream_tracker.sv
module esc_stream_tracker #(
    parameter int AW    = 16,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_ad,
    input  logic          addr_phase,
    input  logic          data_phase,
    input  logic          cyc_read,
    input  logic          cyc_fetch,
    input  logic [1:0]    q_status,
    output logic          insn_stb,
    output logic [7:0]    insn_opcode,
    output logic [7:0]    insn_modrm,
    output logic          insn_has_mem,
    output logic          addr_stb,
    output logic [AW-1:0] op_addr,
    output logic          data_stb,
    output logic [AW-1:0] op_data,
    output logic          ovf_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          ev_fetch_push, ev_dummy_addr, ev_dummy_data;
    logic          sq_pop, sq_flush, sq_empty;
    logic [7:0]    sq_head;
    logic [CW-1:0] sq_count;

    esc_bus_latch u_latch (
        .clk           (clk),
        .rst           (rst),
        .addr_phase    (addr_phase),
        .data_phase    (data_phase),
        .cyc_read      (cyc_read),
        .cyc_fetch     (cyc_fetch),
        .ev_fetch_push (ev_fetch_push),
        .ev_dummy_addr (ev_dummy_addr),
        .ev_dummy_data (ev_dummy_data)
    );

    esc_shadow_queue #(.DEPTH(DEPTH), .BW(8)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (sq_flush),
        .push      (ev_fetch_push),
        .push_data (bus_ad[7:0]),
        .pop       (sq_pop),
        .head      (sq_head),
        .empty     (sq_empty),
        .count     (sq_count),
        .overflow  (ovf_err)
    );

    esc_decoder #(.AW(AW)) u_dec (
        .clk           (clk),
        .rst           (rst),
        .q_status      (q_status),
        .head          (sq_head),
        .q_empty       (sq_empty),
        .ev_dummy_addr (ev_dummy_addr),
        .ev_dummy_data (ev_dummy_data),
        .bus_ad        (bus_ad),
        .q_pop         (sq_pop),
        .q_flush       (sq_flush),
        .insn_stb      (insn_stb),
        .insn_opcode   (insn_opcode),
        .insn_modrm    (insn_modrm),
        .insn_has_mem  (insn_has_mem),
        .addr_stb      (addr_stb),
        .op_addr       (op_addr),
        .data_stb      (data_stb),
        .op_data       (op_data)
    );
endmodule

// File: rtl/esc_tracker_chk.sv
module esc_tracker_chk #(
    parameter  int AW    = 16,
    parameter  int DEPTH = 6,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_ad,
    input logic          addr_phase,
    input logic          cyc_read,
    input logic          cyc_fetch,
    input logic [1:0]    q_status,
    input logic          insn_stb,
    input logic          insn_has_mem,
    input logic          addr_stb,
    input logic [AW-1:0] op_addr,
    input logic          data_stb,
    input logic          ovf_err,
    input logic [CW-1:0] sq_count
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !insn_stb && !addr_stb && !data_stb && !ovf_err && sq_count == '0); // R1

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        q_status == 2'b10 |=> sq_count == '0); // R4

    AST_REG_FORM_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        insn_stb && !insn_has_mem |=> !addr_stb); // R7

    AST_ADDR_FROM_DUMMY: assert property (@(posedge clk) disable iff (rst)
        addr_stb |-> $past(addr_phase) && $past(cyc_read) && !$past(cyc_fetch)
                     && op_addr == $past(bus_ad)); // R7

    AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        data_stb |-> !addr_stb); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        sq_count <= CW'(DEPTH)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R9
endmodule

bind esc_stream_tracker esc_tracker_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_ad       (bus_ad),
    .addr_phase   (addr_phase),
    .cyc_read     (cyc_read),
    .cyc_fetch    (cyc_fetch),
    .q_status     (q_status),
    .insn_stb     (insn_stb),
    .insn_has_mem (insn_has_mem),
    .addr_stb     (addr_stb),
    .op_addr      (op_addr),
    .data_stb     (data_stb),
    .ovf_err      (ovf_err),
    .sq_count     (sq_count)
);

// File: tb/test_esc_stream_tracker.sv
module test_esc_stream_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DEPTH = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_ad = '0;
    logic          addr_phase = 1'b0, data_phase = 1'b0, cyc_read = 1'b0, cyc_fetch = 1'b0;
    logic [1:0]    q_status = 2'b00;
    logic          insn_stb, insn_has_mem, addr_stb, data_stb, ovf_err;
    logic [7:0]    insn_opcode, insn_modrm;
    logic [AW-1:0] op_addr, op_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    esc_stream_tracker #(.AW(AW), .DEPTH(DEPTH)) i_esc_stream_tracker (
        .clk(clk), .rst(rst), .bus_ad(bus_ad), .addr_phase(addr_phase),
        .data_phase(data_phase), .cyc_read(cyc_read), .cyc_fetch(cyc_fetch),
        .q_status(q_status), .insn_stb(insn_stb), .insn_opcode(insn_opcode),
        .insn_modrm(insn_modrm), .insn_has_mem(insn_has_mem), .addr_stb(addr_stb),
        .op_addr(op_addr), .data_stb(data_stb), .op_data(op_data), .ovf_err(ovf_err)
    );

    // behavioural reference model
    logic [7:0]    mq[$];
    bit            m_lread, m_lfetch, m_wait, m_istb, m_hm, m_astb, m_dstb, m_ovf;
    int            m_cap;
    logic [7:0]    m_pend, m_opc, m_mr;
    logic [AW-1:0] m_addr, m_data;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_lread = 0; m_lfetch = 0; m_wait = 0; m_istb = 0; m_hm = 0;
            m_astb = 0; m_dstb = 0; m_ovf = 0; m_cap = 0;
            m_pend = 0; m_opc = 0; m_mr = 0; m_addr = 0; m_data = 0;
        end else begin
            bit push_now, got;
            logic [7:0] b;
            m_istb = 0; m_astb = 0; m_dstb = 0;
            push_now = data_phase && m_lread && m_lfetch;
            if (m_cap == 1 && addr_phase && cyc_read && !cyc_fetch) begin
                m_addr = bus_ad; m_astb = 1; m_cap = 2;
            end else if (m_cap == 2 && data_phase && m_lread && !m_lfetch) begin
                m_data = bus_ad; m_dstb = 1; m_cap = 0;
            end
            if (addr_phase) begin m_lread = cyc_read; m_lfetch = cyc_fetch; end
            if (q_status == 2'b10) begin
                mq.delete(); m_wait = 0;
            end else begin
                got = 0; b = 8'h00;
                if ((q_status == 2'b01 || q_status == 2'b11) && mq.size() > 0) begin
                    b = mq.pop_front(); got = 1;
                end
                if (push_now) begin
                    if (mq.size() < DEPTH) mq.push_back(bus_ad[7:0]);
                    else m_ovf = 1;
                end
                if (q_status == 2'b01) begin
                    if (got && b >= 8'hD8 && b <= 8'hDF) begin m_wait = 1; m_pend = b; end
                    else m_wait = 0;
                end else if (q_status == 2'b11 && got && m_wait) begin
                    m_opc = m_pend; m_mr = b; m_hm = (b[7:6] != 2'b11);
                    m_istb = 1; m_cap = m_hm ? 1 : 0; m_wait = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R6 insn_stb", 32'(insn_stb), 32'(m_istb));
        chk("R6 insn_opcode", 32'(insn_opcode), 32'(m_opc));
        chk("R6 insn_modrm", 32'(insn_modrm), 32'(m_mr));
        chk("R6 insn_has_mem", 32'(insn_has_mem), 32'(m_hm));
        chk("R7 addr_stb", 32'(addr_stb), 32'(m_astb));
        chk("R7 op_addr", 32'(op_addr), 32'(m_addr));
        chk("R8 data_stb", 32'(data_stb), 32'(m_dstb));
        chk("R8 op_data", 32'(op_data), 32'(m_data));
        chk("R9 ovf_err", 32'(ovf_err), 32'(m_ovf));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare_all();
        addr_phase = 0; data_phase = 0; cyc_read = 0; cyc_fetch = 0;
        q_status = 2'b00; bus_ad = '0;
    endtask

    task automatic bus_cycle(input bit rd, input bit ft, input logic [AW-1:0] a,
                             input logic [AW-1:0] d);
        addr_phase = 1; cyc_read = rd; cyc_fetch = ft; bus_ad = a;
        step();
        data_phase = 1; bus_ad = d;
        step();
    endtask

    task automatic fetch(input logic [7:0] b);
        bus_cycle(1, 1, 16'h0100, {8'h00, b});
    endtask

    task automatic qs(input logic [1:0] code);
        q_status = code;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 insn_stb", 32'(insn_stb), 0);
        chk("R1 addr_stb", 32'(addr_stb), 0);
        chk("R1 ovf_err", 32'(ovf_err), 0);
        chk("R1 op_addr", 32'(op_addr), 0);

        // R3 R6 memory-form escape D9 06
        fetch(8'hD9); fetch(8'h06);
        qs(2'b01);
        q_status = 2'b11; step();
        chk("R6 strobe on ModRM pop", 32'(insn_stb), 1);
        chk("R3 opcode order", 32'(insn_opcode), 32'hD9);
        chk("R6 has_mem mod 00", 32'(insn_has_mem), 1);

        // R7 R8 dummy read capture
        addr_phase = 1; cyc_read = 1; bus_ad = 16'h1234; step();
        chk("R7 addr captured", 32'(op_addr), 32'h1234);
        chk("R7 addr strobe", 32'(addr_stb), 1);
        data_phase = 1; bus_ad = 16'hBEEF; step();
        chk("R8 data captured", 32'(op_data), 32'hBEEF);
        chk("R8 data strobe", 32'(data_stb), 1);
        bus_cycle(1, 0, 16'h5555, 16'h6666);
        chk("R8 disarmed after capture", 32'(op_addr), 32'h1234);

        // R5 non-escape and boundary codes
        fetch(8'h90); fetch(8'hD7); fetch(8'hE0);
        qs(2'b01); qs(2'b01); qs(2'b01);
        chk("R5 non-escape ignored", 32'(insn_stb), 0);
        qs(2'b11);
        chk("R10 pop on empty", 32'(insn_stb), 0);
        fetch(8'hDF); fetch(8'hC0);
        qs(2'b01); qs(2'b11);
        chk("R5 DF is escape", 32'(insn_stb), 1);
        chk("R6 reg form", 32'(insn_has_mem), 0);
        bus_cycle(1, 0, 16'h7777, 16'h8888);
        chk("R7 reg form no capture", 32'(op_addr), 32'h1234);

        // R4 flush
        fetch(8'hD8); fetch(8'h05);
        qs(2'b10);
        qs(2'b01); qs(2'b11);
        chk("R4 flush emptied queue", 32'(insn_stb), 0);
        fetch(8'hDC);
        qs(2'b01);
        qs(2'b10);
        fetch(8'h46);
        qs(2'b11);
        chk("R4 flush cancels pending escape", 32'(insn_stb), 0);

        // R2 write and non-fetch reads do not enter the queue
        bus_cycle(0, 1, 16'h0200, 16'h00D9);
        bus_cycle(1, 0, 16'h0300, 16'h00DA);
        qs(2'b01);
        qs(2'b11);
        chk("R2 non-fetch not queued", 32'(insn_stb), 0);

        // R9 overflow
        qs(2'b10);
        for (int i = 0; i < DEPTH; i++) fetch(8'hDA + 8'(i));
        chk("R9 full no overflow", 32'(ovf_err), 0);
        fetch(8'h11);
        chk("R9 overflow raised", 32'(ovf_err), 1);
        qs(2'b01); qs(2'b11);
        chk("R9 order kept after drop", 32'(insn_modrm), 32'hDB);
        qs(2'b00);
        chk("R9 sticky", 32'(ovf_err), 1);

        // pop with push in same cycle when full
        qs(2'b10);
        for (int i = 0; i < DEPTH; i++) fetch(8'hDD);
        addr_phase = 1; cyc_read = 1; cyc_fetch = 1; bus_ad = 16'h0400; step();
        data_phase = 1; bus_ad = 16'h0044; q_status = 2'b01; step();
        for (int i = 0; i < DEPTH; i++) qs(2'b11);
        qs(2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule